// File: doc/BRIEF.md
# Mesh Router Input Port with Per-Output Queues

This block is the receiving side of one input of a five-port router in a two-dimensional mesh. Each packet arrives with the X and Y coordinates of its destination. The port compares these coordinates with the router's own position, which is fixed by parameters. It then writes the packet into one of five queues. Each queue belongs to one output direction: local delivery, X+, X-, Y+ or Y-. The route is dimension-order: a packet first moves along X until its X coordinate matches, and only then moves along Y.

Each queue shows its oldest packet to its output, together with a valid flag. Each output has its own ready input. A queue pops its head in any cycle where its valid and ready are both high, and it does not wait on any other queue. Several outputs can therefore drain in the same cycle. A packet stuck behind a busy output only holds up packets bound for that same output. Input backpressure appears only when the queue the incoming packet is headed for is full.

Each queue is controlled by a three-state occupancy machine:
- Q_EMPTY, with no entries.
- Q_PARTIAL, with some entries but room left.
- Q_FULL, with every slot used.

The transitions are:
- FILL_FIRST: Q_EMPTY to Q_PARTIAL on a push, or straight to Q_FULL when the depth is one.
- FILL_LAST: Q_PARTIAL to Q_FULL on a push without a pop while one slot remains.
- DRAIN_LAST: Q_PARTIAL to Q_EMPTY on a pop without a push while one entry remains.
- DRAIN_FROM_FULL: Q_FULL to Q_PARTIAL on a pop, or to Q_EMPTY at depth one.

Every other case holds the current state.

Top module: `voq_input_port`

## Requirements
- R1: A packet whose destination X is greater than the router's X goes to output index 1 (X+), whatever its Y.
- R2: A packet whose destination X is less than the router's X goes to output index 2 (X-), whatever its Y.
- R3: When the destination X equals the router's X, a larger destination Y goes to index 3 (Y+) and a smaller one to index 4 (Y-).
- R4: A packet whose destination matches the router's X and Y goes to index 0 (local).
- R5: Each queue presents packets in the order they were accepted, and a pop happens in the cycle where its valid and ready are both high.
- R6: The input ready signal is low exactly when the queue chosen for the presented packet is full.
- R7: A full or stalled queue does not stop packets for other outputs from being accepted and delivered.
- R8: Queues pop independently, so several outputs can each remove a packet in the same cycle.
- R9: After reset every queue reports empty and no output is valid. A queue's full flag is set when it holds DEPTH entries. Empty and full are never set together.
- R10: While an output is valid and its ready is low, its head packet and valid flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Port will take the presented packet this cycle |
| in_dst_x | input | COORD_W | Destination X coordinate |
| in_dst_y | input | COORD_W | Destination Y coordinate |
| in_payload | input | DATA_W | Packet payload |
| out_valid | output | 5 | Per-output head valid (index 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-) |
| out_ready | input | 5 | Per-output ready, same indexing |
| out_dst_x | output | 5*COORD_W | Head destination X per output |
| out_dst_y | output | 5*COORD_W | Head destination Y per output |
| out_payload | output | 5*DATA_W | Head payload per output |
| q_empty | output | 5 | Per-queue empty flag |
| q_full | output | 5 | Per-queue full flag |

## Verification
Every destination on a 3-bit coordinate grid is sent once through an otherwise idle port. This separates the five route regions and their boundaries, where X or Y exactly equals the router's own coordinate. A second pattern fills the X+ queue while its output is stalled and then offers a Y- packet. Refusing the first and accepting the second shows that backpressure is tied to the target queue and is not global. The stalled head is observed over several cycles and then drained one entry at a time, which checks that it stays stable and that order is kept. Finally, one packet is placed in each of the five queues and all outputs are made ready at once, which shows whether the queues drain in parallel.

// File: rtl/voq_pkg.sv
package voq_pkg;
    localparam int NUM_DIRS = 5;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_XP    = 3'd1,
        DIR_XM    = 3'd2,
        DIR_YP    = 3'd3,
        DIR_YM    = 3'd4
    } dir_e;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_e;
endpackage

// File: rtl/voq_route_xy.sv
module voq_route_xy
    import voq_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 1
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output dir_e               dir
);
    localparam logic [COORD_W-1:0] HOME_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HOME_Y = COORD_W'(MY_Y);

    // X is resolved completely before Y is considered.
    always_comb begin
        if (dst_x > HOME_X)
            dir = DIR_XP;
        else if (dst_x < HOME_X)
            dir = DIR_XM;
        else if (dst_y > HOME_Y)
            dir = DIR_YP;
        else if (dst_y < HOME_Y)
            dir = DIR_YM;
        else
            dir = DIR_LOCAL;
    end
endmodule

// File: rtl/voq_queue.sv
module voq_queue
    import voq_pkg::*;
#(
    parameter int WIDTH = 14,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_ready,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    output logic             is_empty,
    output logic             is_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_LEFT  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE_ENTRY = CNT_W'(1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    qstate_e          state, state_nxt;
    logic             do_pop, do_push;

    assign do_pop  = pop_ready && (state != Q_EMPTY);
    assign do_push = push && (state != Q_FULL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= Q_EMPTY;
        else
            state <= state_nxt;
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (do_push)
                    state_nxt = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;   // FILL_FIRST
            end
            Q_PARTIAL: begin
                if (do_push && !do_pop && count == ONE_LEFT)
                    state_nxt = Q_FULL;                              // FILL_LAST
                else if (do_pop && !do_push && count == ONE_ENTRY)
                    state_nxt = Q_EMPTY;                             // DRAIN_LAST
            end
            Q_FULL: begin
                if (do_pop)
                    state_nxt = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;  // DRAIN_FROM_FULL
            end
            default: state_nxt = Q_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        is_empty   = (state == Q_EMPTY);
        is_full    = (state == Q_FULL);
        head_valid = (state != Q_EMPTY);
        head_data  = slots[rd_ptr];
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/voq_input_port.sv
module voq_input_port
    import voq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int COORD_W = 3,
    parameter int DEPTH   = 2,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [COORD_W-1:0]            in_dst_x,
    input  logic [COORD_W-1:0]            in_dst_y,
    input  logic [DATA_W-1:0]             in_payload,
    output logic [NUM_DIRS-1:0]           out_valid,
    input  logic [NUM_DIRS-1:0]           out_ready,
    output logic [NUM_DIRS*COORD_W-1:0]   out_dst_x,
    output logic [NUM_DIRS*COORD_W-1:0]   out_dst_y,
    output logic [NUM_DIRS*DATA_W-1:0]    out_payload,
    output logic [NUM_DIRS-1:0]           q_empty,
    output logic [NUM_DIRS-1:0]           q_full
);
    localparam int ENTRY_W = 2 * COORD_W + DATA_W;

    dir_e                route;
    logic [NUM_DIRS-1:0] target;
    logic [NUM_DIRS-1:0] push_vec;
    logic [ENTRY_W-1:0]  entry_in;

    voq_route_xy #(
        .COORD_W (COORD_W),
        .MY_X    (MY_X),
        .MY_Y    (MY_Y)
    ) u_route (
        .dst_x (in_dst_x),
        .dst_y (in_dst_y),
        .dir   (route)
    );

    assign entry_in = {in_dst_x, in_dst_y, in_payload};
    assign in_ready = ~|(target & q_full);

    for (genvar k = 0; k < NUM_DIRS; k++) begin : g_queue
        logic [ENTRY_W-1:0] head;

        assign target[k]   = (route == dir_e'(k));
        assign push_vec[k] = in_valid && in_ready && target[k];

        voq_queue #(
            .WIDTH (ENTRY_W),
            .DEPTH (DEPTH)
        ) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .push       (push_vec[k]),
            .push_data  (entry_in),
            .pop_ready  (out_ready[k]),
            .head_valid (out_valid[k]),
            .head_data  (head),
            .is_empty   (q_empty[k]),
            .is_full    (q_full[k])
        );

        assign out_dst_x[k*COORD_W +: COORD_W] = head[ENTRY_W-1 -: COORD_W];
        assign out_dst_y[k*COORD_W +: COORD_W] = head[DATA_W +: COORD_W];
        assign out_payload[k*DATA_W +: DATA_W] = head[DATA_W-1:0];
    end
endmodule

// File: rtl/voq_input_port_checker.sv
module voq_input_port_checker
    import voq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int COORD_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic [NUM_DIRS-1:0]         out_valid,
    input logic [NUM_DIRS-1:0]         out_ready,
    input logic [NUM_DIRS*COORD_W-1:0] out_dst_x,
    input logic [NUM_DIRS*COORD_W-1:0] out_dst_y,
    input logic [NUM_DIRS*DATA_W-1:0]  out_payload,
    input logic [NUM_DIRS-1:0]         q_empty,
    input logic [NUM_DIRS-1:0]         q_full
);
    // Backpressure only ever comes from some full queue.
    p_refuse_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (|q_full));

    for (genvar k = 0; k < NUM_DIRS; k++) begin : g_chk
        p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(q_empty[k] && q_full[k]));

        p_valid_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k] == !q_empty[k]);

        p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && !out_ready[k]) |=>
                (out_valid[k]
                 && $stable(out_payload[k*DATA_W +: DATA_W])
                 && $stable(out_dst_x[k*COORD_W +: COORD_W])
                 && $stable(out_dst_y[k*COORD_W +: COORD_W])));

        p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (q_full[k] && !out_ready[k]) |=> q_full[k]);
    end
endmodule

bind voq_input_port voq_input_port_checker #(
    .DATA_W  (DATA_W),
    .COORD_W (COORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_dst_x   (out_dst_x),
    .out_dst_y   (out_dst_y),
    .out_payload (out_payload),
    .q_empty     (q_empty),
    .q_full      (q_full)
);

// File: tb/voq_input_port_test.sv
module voq_input_port_test;
    localparam int DW = 8;
    localparam int CW = 3;
    localparam int DP = 2;
    localparam int HX = 2;
    localparam int HY = 1;
    localparam int ND = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [CW-1:0] in_dst_x = '0;
    logic [CW-1:0] in_dst_y = '0;
    logic [DW-1:0] in_payload = '0;
    logic [ND-1:0] out_valid;
    logic [ND-1:0] out_ready = '0;
    logic [ND*CW-1:0] out_dst_x, out_dst_y;
    logic [ND*DW-1:0] out_payload;
    logic [ND-1:0] q_empty, q_full;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    voq_input_port #(.DATA_W(DW), .COORD_W(CW), .DEPTH(DP), .MY_X(HX), .MY_Y(HY)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_dst_x(out_dst_x),
        .out_dst_y(out_dst_y), .out_payload(out_payload), .q_empty(q_empty), .q_full(q_full)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    function automatic int exp_dir(input int x, input int y);
        if (x > HX) return 1;
        if (x < HX) return 2;
        if (y > HY) return 3;
        if (y < HY) return 4;
        return 0;
    endfunction

    // Present one packet for one cycle; returns in_ready seen before the edge.
    task automatic send(input int x, input int y, input int p, output bit acc);
        @(negedge clk);
        in_valid = 1'b1;
        in_dst_x = CW'(x);
        in_dst_y = CW'(y);
        in_payload = DW'(p);
        #1 acc = in_ready;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop(input logic [ND-1:0] mask);
        @(negedge clk);
        out_ready = mask;
        @(negedge clk);
        out_ready = '0;
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(q_empty == 5'h1F, "R9 reset empty", q_empty, 31);
        check(out_valid == 0 && q_full == 0, "R9 reset valid/full", out_valid, 0);

        // R1 R2 R3 R4: exhaustive destination sweep
        for (int x = 0; x < 8; x++) begin
            for (int y = 0; y < 8; y++) begin
                int d;
                d = exp_dir(x, y);
                send(x, y, x * 8 + y, acc);
                check(acc, "R6 accept idle", acc, 1);
                check(out_valid == ND'(1 << d),
                      (d == 1) ? "R1 route" : (d == 2) ? "R2 route" : (d == 0) ? "R4 route" : "R3 route",
                      out_valid, 1 << d);
                check(out_payload[d*DW +: DW] == DW'(x * 8 + y) &&
                      out_dst_x[d*CW +: CW] == CW'(x) && out_dst_y[d*CW +: CW] == CW'(y),
                      "R5 head content", out_payload[d*DW +: DW], x * 8 + y);
                pop(ND'(1 << d));
                check(q_empty == 5'h1F, "R5 pop empties", q_empty, 31);
            end
        end

        // R6 R7: fill X+ queue, then offer X+ (refused) and Y- (accepted)
        send(6, 3, 8'hA1, acc);
        send(7, 0, 8'hA2, acc);
        check(q_full[1] == 1'b1, "R9 full flag", q_full[1], 1);
        send(5, 5, 8'hA3, acc);
        check(acc == 1'b0, "R6 refuse full target", acc, 0);
        send(2, 0, 8'hB1, acc);
        check(acc == 1'b1, "R7 other output accepted", acc, 1);
        check(out_valid[4] && out_payload[4*DW +: DW] == 8'hB1, "R7 Y- head", out_payload[4*DW +: DW], 8'hB1);
        pop(5'b10000);
        check(q_empty[4], "R7 Y- drained past stall", q_empty[4], 1);
        // R10: stalled head stays put
        repeat (4) @(negedge clk);
        check(out_valid[1] && out_payload[1*DW +: DW] == 8'hA1, "R10 stalled head", out_payload[1*DW +: DW], 8'hA1);
        // R5: order within the queue
        pop(5'b00010);
        check(out_payload[1*DW +: DW] == 8'hA2 && !q_full[1], "R5 second in order", out_payload[1*DW +: DW], 8'hA2);
        pop(5'b00010);
        check(q_empty[1], "R5 drained", q_empty[1], 1);

        // R8: one packet per queue, all drained in one cycle
        send(2, 1, 8'hC0, acc);
        send(4, 1, 8'hC1, acc);
        send(0, 1, 8'hC2, acc);
        send(2, 6, 8'hC3, acc);
        send(2, 0, 8'hC4, acc);
        check(out_valid == 5'h1F, "R8 all loaded", out_valid, 31);
        for (int k = 0; k < ND; k++)
            check(out_payload[k*DW +: DW] == DW'(8'hC0 + k), "R8 head per queue", out_payload[k*DW +: DW], 8'hC0 + k);
        pop(5'h1F);
        check(q_empty == 5'h1F, "R8 parallel drain", q_empty, 31);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule